// File: doc/BRIEF.md
# Dual-Consumer Interrupt Enable and Steering Bank

This block gathers 32 level-sensitive interrupt lines and presents them to two consumers, a main processor and a coprocessor. Each consumer owns an enable mask and a steering mask. The steering mask sends each enabled line to that consumer's normal request (IRQ) or to its fast request (FIQ). Software changes the enable masks through write-one-to-set and write-one-to-clear aliases, so it can unmask or mask single lines without a read-modify-write. A shared software trigger mask is ORed into the raw lines. Software uses it to inject a request or to replay one, and clears the bit again when it finishes servicing.

All state sits behind a simple 32-bit register bus with byte offsets. The raw lines pass through a two-stage synchronizer. Every output (the four request lines, both pending vectors and the read data) is registered. A system with more lines places several copies of the block side by side: line n goes to copy n/32, at bit n mod 32.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset, the enable, steering and trigger masks are zero, all four request outputs and both pending vectors are low, and the read data is zero.
- R2: Main enable mask: writing 0x24 sets the bits written as one, and writing 0x28 clears the bits written as one. Bits written as zero keep their value. Writing 0x20 loads the whole mask. Reads of 0x20, 0x24 and 0x28 all return the mask.
- R3: Writing all ones to 0x28 disables every main line in a single write. A later write to 0x24 then leaves only the bits it sets enabled.
- R4: Main steering mask at 0x2C is a plain read/write register. Bit value 0 sends the line to IRQ and 1 sends it to FIQ. cpu_irq_o is the OR of pending main lines steered 0, and cpu_fiq_o is the OR of those steered 1. Pending is (synchronized raw OR trigger) AND enable.
- R5: The coprocessor has its own enable mask at 0x30, with set alias 0x34 and clear alias 0x38, and its own steering mask at 0x3C. These drive cop_irq_o, cop_fiq_o and cop_pend_o only, and the main outputs are left alone.
- R6: Trigger mask: 0x14 loads it, 0x18 sets bits and 0x1C clears bits. All three offsets read the mask. Its bits are ORed into the raw lines for both consumers. Clearing a bit removes the request it made.
- R7: A read of 0x08 returns the main pending vector ANDed with the main steering mask, which is the lines that are pending and steered to FIQ. Writes to 0x08 change nothing.
- R8: Raw lines are levels passed through two flip-flops and never latched. A raw change driven between edges shows on the outputs after the third rising edge, and a dropped line stops requesting with the same delay.
- R9: Reads of any offset not named above return zero, and writes to those offsets change no register.
- R10: Request outputs and pending vectors are registered. A register write takes effect on them one rising edge after the edge that stores the write.
- R11: Read data is stored on the edge after a read request and holds its value until the next read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_raw_i | input | 32 | Raw level interrupt lines |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| cpu_irq_o | output | 1 | Main processor normal request |
| cpu_fiq_o | output | 1 | Main processor fast request |
| cop_irq_o | output | 1 | Coprocessor normal request |
| cop_fiq_o | output | 1 | Coprocessor fast request |
| cpu_pend_o | output | 32 | Main pending vector |
| cop_pend_o | output | 32 | Coprocessor pending vector |

## Verification
The bench sets enable bits one at a time and then checks that untouched bits survive. A design that treated an alias as a plain store would lose the earlier bits. It clears every bit with one all-ones write and then re-enables a single line, which catches a clear alias that ignores the upper bits. It also walks a raw line through the synchronizer edge by edge, so an extra stage or a missing stage shows up as a request one cycle early or one cycle late. Writes to the read-only FIQ view and to unmapped offsets are followed by read-back of every mask, and a decoder that aliased those offsets onto real registers would corrupt a mask. Finally, a triggered line is used to show that both consumers see the trigger mask and that steering one consumer leaves the other's requests untouched.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
  // byte offsets of the register window
  localparam int unsigned OFS_FIQ_VIEW = 32'h08;
  localparam int unsigned OFS_TRG_LD   = 32'h14;
  localparam int unsigned OFS_TRG_SET  = 32'h18;
  localparam int unsigned OFS_TRG_CLR  = 32'h1C;
  // per-consumer group: base + 0 load, +4 set, +8 clear, +C steering
  localparam int unsigned OFS_GRP_BASE = 32'h20;
  localparam int unsigned OFS_GRP_STEP = 32'h10;
  localparam int unsigned OFS_EN_LD    = 32'h0;
  localparam int unsigned OFS_EN_SET   = 32'h4;
  localparam int unsigned OFS_EN_CLR   = 32'h8;
  localparam int unsigned OFS_STEER    = 32'hC;

  typedef enum logic [0:0] {
    CONS_MAIN = 1'b0,
    CONS_COP  = 1'b1
  } cons_e;

  function automatic int unsigned grp_base(input int unsigned c);
    return OFS_GRP_BASE + c * OFS_GRP_STEP;
  endfunction
endpackage

// File: rtl/irqb_sync2.sv
module irqb_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/irqb_alias_reg.sv
module irqb_alias_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_d;
  logic         ce;

  assign ce = ld_i | set_i | clr_i;

  always_comb begin
    q_d = q_q;
    if (ld_i)       q_d = wdata_i;
    else if (set_i) q_d = q_q | wdata_i;
    else if (clr_i) q_d = q_q & ~wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_q <= '0;
    else if (ce) q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/irqb_route.sv
module irqb_route #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] steer_i,
  output logic [W-1:0] pend_o,
  output logic         irq_o,
  output logic         fiq_o
);
  logic [W-1:0] pend_d, pend_q;
  logic         irq_d, fiq_d, irq_q, fiq_q;

  always_comb begin
    pend_d = lvl_i & en_i;
    irq_d  = |(pend_d & ~steer_i);
    fiq_d  = |(pend_d & steer_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
      fiq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= irq_d;
      fiq_q  <= fiq_d;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = irq_q;
  assign fiq_o  = fiq_q;
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irqb_pkg::*;
#(
  parameter int LINES  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_raw_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [LINES-1:0]  bus_wdata_i,
  output logic [LINES-1:0]  bus_rdata_o,
  output logic              cpu_irq_o,
  output logic              cpu_fiq_o,
  output logic              cop_irq_o,
  output logic              cop_fiq_o,
  output logic [LINES-1:0]  cpu_pend_o,
  output logic [LINES-1:0]  cop_pend_o
);
  localparam int NCONS = 2;

  logic             wr, rd;
  logic [LINES-1:0] raw_sync, trg_q, lvl;
  logic [LINES-1:0] en_q    [NCONS];
  logic [LINES-1:0] steer_q [NCONS];
  logic [LINES-1:0] pend_q  [NCONS];
  logic             irq_q   [NCONS];
  logic             fiq_q   [NCONS];
  logic [LINES-1:0] rdata_d, rdata_q;

  assign wr = bus_req_i & bus_we_i;
  assign rd = bus_req_i & ~bus_we_i;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  irqb_sync2 #(.W(LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(irq_raw_i), .q_o(raw_sync)
  );

  irqb_alias_reg #(.W(LINES)) u_trg (
    .clk(clk), .rst_n(rst_n),
    .ld_i (wr & hit(bus_addr_i, OFS_TRG_LD)),
    .set_i(wr & hit(bus_addr_i, OFS_TRG_SET)),
    .clr_i(wr & hit(bus_addr_i, OFS_TRG_CLR)),
    .wdata_i(bus_wdata_i), .q_o(trg_q)
  );

  assign lvl = raw_sync | trg_q;

  for (genvar c = 0; c < NCONS; c++) begin : g_cons
    localparam int unsigned B = grp_base(c);

    irqb_alias_reg #(.W(LINES)) u_en (
      .clk(clk), .rst_n(rst_n),
      .ld_i (wr & hit(bus_addr_i, B + OFS_EN_LD)),
      .set_i(wr & hit(bus_addr_i, B + OFS_EN_SET)),
      .clr_i(wr & hit(bus_addr_i, B + OFS_EN_CLR)),
      .wdata_i(bus_wdata_i), .q_o(en_q[c])
    );

    irqb_alias_reg #(.W(LINES)) u_steer (
      .clk(clk), .rst_n(rst_n),
      .ld_i (wr & hit(bus_addr_i, B + OFS_STEER)),
      .set_i(1'b0), .clr_i(1'b0),
      .wdata_i(bus_wdata_i), .q_o(steer_q[c])
    );

    irqb_route #(.W(LINES)) u_route (
      .clk(clk), .rst_n(rst_n),
      .lvl_i(lvl), .en_i(en_q[c]), .steer_i(steer_q[c]),
      .pend_o(pend_q[c]), .irq_o(irq_q[c]), .fiq_o(fiq_q[c])
    );
  end

  // read decode
  always_comb begin
    rdata_d = '0;
    if (hit(bus_addr_i, OFS_FIQ_VIEW))
      rdata_d = pend_q[CONS_MAIN] & steer_q[CONS_MAIN];
    if (hit(bus_addr_i, OFS_TRG_LD) || hit(bus_addr_i, OFS_TRG_SET) ||
        hit(bus_addr_i, OFS_TRG_CLR))
      rdata_d = trg_q;
    for (int c = 0; c < NCONS; c++) begin
      if (hit(bus_addr_i, grp_base(c) + OFS_EN_LD) ||
          hit(bus_addr_i, grp_base(c) + OFS_EN_SET) ||
          hit(bus_addr_i, grp_base(c) + OFS_EN_CLR))
        rdata_d = en_q[c];
      if (hit(bus_addr_i, grp_base(c) + OFS_STEER))
        rdata_d = steer_q[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (rd) rdata_q <= rdata_d;
  end

  assign bus_rdata_o = rdata_q;
  assign cpu_irq_o   = irq_q[CONS_MAIN];
  assign cpu_fiq_o   = fiq_q[CONS_MAIN];
  assign cop_irq_o   = irq_q[CONS_COP];
  assign cop_fiq_o   = fiq_q[CONS_COP];
  assign cpu_pend_o  = pend_q[CONS_MAIN];
  assign cop_pend_o  = pend_q[CONS_COP];
endmodule

// File: rtl/irqb_checker.sv
module irqb_checker #(
  parameter int LINES  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [LINES-1:0]  bus_wdata,
  input logic [LINES-1:0]  bus_rdata,
  input logic [LINES-1:0]  cpu_en,
  input logic [LINES-1:0]  cop_en,
  input logic [LINES-1:0]  trg,
  input logic              cpu_irq,
  input logic              cpu_fiq
);
  logic wr, rd, mapped;
  assign wr = bus_req & bus_we;
  assign rd = bus_req & ~bus_we;

  always_comb begin
    case (bus_addr)
      ADDR_W'(8'h08), ADDR_W'(8'h14), ADDR_W'(8'h18), ADDR_W'(8'h1C),
      ADDR_W'(8'h20), ADDR_W'(8'h24), ADDR_W'(8'h28), ADDR_W'(8'h2C),
      ADDR_W'(8'h30), ADDR_W'(8'h34), ADDR_W'(8'h38), ADDR_W'(8'h3C): mapped = 1'b1;
      default: mapped = 1'b0;
    endcase
  end

  p_set_alias_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == ADDR_W'(8'h24)) |=> ((cpu_en & $past(bus_wdata)) == $past(bus_wdata)));

  p_keep_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == ADDR_W'(8'h24)) |=>
      ((cpu_en & ~$past(bus_wdata)) == ($past(cpu_en) & ~$past(bus_wdata))));

  p_clr_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == ADDR_W'(8'h28)) |=> ((cpu_en & $past(bus_wdata)) == '0));

  p_cop_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == ADDR_W'(8'h38)) |=> ((cop_en & $past(bus_wdata)) == '0));

  p_trg_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == ADDR_W'(8'h1C)) |=> ((trg & $past(bus_wdata)) == '0));

  p_quiet_when_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cpu_en) == '0) |-> (!cpu_irq && !cpu_fiq));

  p_unmapped_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !mapped) |=> (bus_rdata == '0));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(bus_rdata));
endmodule

bind irq_bank_ctrl irqb_checker #(.LINES(LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .bus_req(bus_req_i), .bus_we(bus_we_i), .bus_addr(bus_addr_i),
  .bus_wdata(bus_wdata_i), .bus_rdata(bus_rdata_o),
  .cpu_en(en_q[0]), .cop_en(en_q[1]), .trg(trg_q),
  .cpu_irq(cpu_irq_o), .cpu_fiq(cpu_fiq_o)
);

// File: tb/tb_irq_bank_ctrl.sv
module tb_irq_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_raw;
  logic        bus_req, bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        cpu_irq, cpu_fiq, cop_irq, cop_fiq;
  logic [31:0] cpu_pend, cop_pend;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  irq_bank_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_raw_i(irq_raw),
    .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .cpu_irq_o(cpu_irq), .cpu_fiq_o(cpu_fiq),
    .cop_irq_o(cop_irq), .cop_fiq_o(cop_fiq),
    .cpu_pend_o(cpu_pend), .cop_pend_o(cop_pend)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input string tag, input logic [7:0] a, input logic [31:0] exp);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  // monitor: pops one expectation per read and compares the stored data
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && bus_req && !bus_we) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          check("scoreboard underflow", 32'h1, 32'h0);
        end else begin
          check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; irq_raw = '0;
    bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 outputs", {28'h0, cpu_irq, cpu_fiq, cop_irq, cop_fiq}, 32'h0);
    check("R1 cpu_pend", cpu_pend, 32'h0);
    check("R1 cop_pend", cop_pend, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    bus_read("R1 main enable", 8'h20, 32'h0);
    bus_read("R1 main steer", 8'h2C, 32'h0);
    bus_read("R1 trigger", 8'h14, 32'h0);

    // R2 set/clear aliases keep untouched bits
    bus_write(8'h24, 32'h0000_00F0);
    bus_read("R2 set first", 8'h20, 32'h0000_00F0);
    bus_write(8'h24, 32'h0000_0F00);
    bus_read("R2 set keeps", 8'h24, 32'h0000_0FF0);
    bus_write(8'h28, 32'h0000_0030);
    bus_read("R2 clr keeps", 8'h28, 32'h0000_0FC0);

    // R4 main request with line 6 raw, steered to IRQ
    irq_raw = 32'h0000_0040;
    idle(4);
    check("R4 cpu irq", {31'h0, cpu_irq}, 32'h1);
    check("R4 cpu fiq", {31'h0, cpu_fiq}, 32'h0);
    check("R4 cpu_pend", cpu_pend, 32'h0000_0040);
    check("R5 cop quiet", {30'h0, cop_irq, cop_fiq}, 32'h0);

    // R10 steer line 6 to FIQ; visible one edge after the storing edge
    bus_write(8'h2C, 32'h0000_0040);
    check("R10 irq not yet", {31'h0, cpu_irq}, 32'h1);
    check("R10 fiq not yet", {31'h0, cpu_fiq}, 32'h0);
    idle(1);
    check("R4 fiq steered", {31'h0, cpu_fiq}, 32'h1);
    check("R4 irq off", {31'h0, cpu_irq}, 32'h0);

    // R7 FIQ view, read-only
    bus_read("R7 fiq view", 8'h08, 32'h0000_0040);
    bus_write(8'h08, 32'hFFFF_FFFF);
    bus_read("R7 view after write", 8'h08, 32'h0000_0040);
    bus_read("R7 steer untouched", 8'h2C, 32'h0000_0040);
    bus_read("R7 enable untouched", 8'h20, 32'h0000_0FC0);

    // R3 clear-all then a single set
    bus_write(8'h28, 32'hFFFF_FFFF);
    bus_write(8'h24, 32'h0000_0008);
    bus_read("R3 only new bit", 8'h20, 32'h0000_0008);
    check("R3 no request", {30'h0, cpu_irq, cpu_fiq}, 32'h0);
    check("R3 pend empty", cpu_pend, 32'h0);

    // R6 trigger line 3
    bus_write(8'h18, 32'h0000_0008);
    idle(1);
    check("R6 forced pend", cpu_pend, 32'h0000_0008);
    check("R6 forced irq", {31'h0, cpu_irq}, 32'h1);
    bus_read("R6 trigger read", 8'h14, 32'h0000_0008);
    bus_read("R6 clr alias read", 8'h1C, 32'h0000_0008);
    bus_write(8'h1C, 32'h0000_0008);
    idle(1);
    check("R6 trigger removed", {31'h0, cpu_irq}, 32'h0);

    // R5 coprocessor group
    bus_write(8'h34, 32'h0000_0040);
    bus_write(8'h3C, 32'h0000_0040);
    idle(1);
    check("R5 cop fiq", {31'h0, cop_fiq}, 32'h1);
    check("R5 cop irq", {31'h0, cop_irq}, 32'h0);
    check("R5 cop pend", cop_pend, 32'h0000_0040);
    check("R5 main unaffected", {30'h0, cpu_irq, cpu_fiq}, 32'h0);
    bus_read("R5 cop enable", 8'h30, 32'h0000_0040);
    bus_read("R5 cop clr alias", 8'h38, 32'h0000_0040);
    bus_read("R5 cop steer", 8'h3C, 32'h0000_0040);
    bus_write(8'h18, 32'h0000_0001);
    bus_write(8'h34, 32'h0000_0001);
    idle(1);
    check("R6 trigger reaches cop", {31'h0, cop_irq}, 32'h1);
    bus_write(8'h1C, 32'h0000_0001);
    idle(1);
    check("R6 cop trigger removed", {31'h0, cop_irq}, 32'h0);

    // R8 synchronizer latency, level not latched
    bus_write(8'h24, 32'h0000_0100);
    idle(2);
    irq_raw = 32'h0000_0140;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R8 after two edges", {31'h0, cpu_irq}, 32'h0);
    idle(1);
    check("R8 after three edges", {31'h0, cpu_irq}, 32'h1);
    irq_raw = 32'h0000_0040;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R8 drop two edges", {31'h0, cpu_irq}, 32'h1);
    idle(1);
    check("R8 drop three edges", {31'h0, cpu_irq}, 32'h0);

    // R2 direct load of main enable
    bus_write(8'h20, 32'h0000_0108);
    bus_read("R2 direct load", 8'h20, 32'h0000_0108);

    // R9 unmapped offsets
    bus_read("R9 read 0x00", 8'h00, 32'h0);
    bus_read("R9 read 0x10", 8'h10, 32'h0);
    bus_read("R9 read 0x40", 8'h40, 32'h0);
    bus_write(8'h0C, 32'hFFFF_FFFF);
    bus_write(8'h40, 32'hFFFF_FFFF);
    bus_read("R9 main enable kept", 8'h20, 32'h0000_0108);
    bus_read("R9 cop enable kept", 8'h30, 32'h0000_0041);
    bus_read("R9 steer kept", 8'h2C, 32'h0000_0040);
    bus_read("R9 trigger kept", 8'h14, 32'h0);

    // R11 read data holds between reads
    bus_read("R11 read", 8'h30, 32'h0000_0041);
    idle(3);
    check("R11 hold", bus_rdata, 32'h0000_0041);

    idle(2);
    check("scoreboard drained", exp_q.size(), 32'h0);
    summary();
  end
endmodule